// File: doc/BRIEF.md
# Single-Cycle Nine-Instruction 32-bit Processor

This block is a 32-bit processor that completes every instruction in one clock: it fetches, decodes, executes, accesses data memory and writes back on the same rising edge. It supports load word, store word, add, subtract, and, or, set-on-less-than, branch-if-equal and an unconditional jump. It holds a 32-entry register file of 32-bit words, a separate instruction store and a separate data store. Both stores are word arrays, indexed by byte address with the two low bits dropped.

The surrounding environment preloads both stores through a load port while reset is held. It then releases reset and lets the program run. The program counter is visible at the ports. A register and a data word can be inspected through two peek ports, each of which returns its value one clock after the address is presented.

Top module: `sc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter is set to 0, and no register or data word is written by the program.
- R2: An instruction whose bits [31:26] are 0x00 is a register operation. Its fields are rs in bits [25:21], rt in bits [20:16], rd in bits [15:11], an ignored shift field in bits [10:6] and the function code in bits [5:0]. Function code 0x20 writes rs+rt to rd, 0x22 writes rs-rt, 0x24 writes rs AND rt, and 0x25 writes rs OR rt.
- R3: Function code 0x2A writes 1 to rd when rs is less than rt as signed two's-complement values, and 0 otherwise.
- R4: Opcode 0x23 loads a word. The address is rs plus the sign-extended 16-bit immediate in bits [15:0]. The word index ignores address bits [1:0]. The loaded word is written to rt.
- R5: Opcode 0x2B stores rt to the data word at rs plus the sign-extended immediate, with the same indexing as R4, on the rising edge.
- R6: Opcode 0x04 branches when rs equals rt, to PC+4 plus the sign-extended immediate times 4; this includes negative offsets. When rs and rt differ it goes to PC+4.
- R7: Opcode 0x02 jumps to the concatenation of bits [31:28] of PC+4, the 26-bit field in bits [25:0], and two zero bits.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: Every instruction other than a taken branch or a jump advances the PC by 4, and the PC stays word-aligned.
- R10: With `ld_we` high, `ld_data` is written at the rising edge to the word at byte address `ld_addr`. That word is in data memory when `ld_dmem` is 1 and in instruction memory when it is 0. Each peek output shows the value addressed at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Preload write enable |
| ld_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| ld_addr | input | 32 | Preload byte address |
| ld_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| peek_reg | input | 5 | Register to inspect |
| peek_reg_data | output | 32 | Registered value of the inspected register |
| peek_addr | input | 32 | Data byte address to inspect |
| peek_word | output | 32 | Registered data word at that address |

## Verification
The bench builds the processor with its default sizes, 64 words of instruction memory and 64 words of data memory. This is enough for a program that uses every opcode and function code, skips code with a forward branch and with a jump, and parks itself in a backward self-branch. Load and store addresses are deliberately misaligned and use negative offsets, which exercises the indexing that drops the low bits. Because the memories are small, the upper PC bits that the jump carries over are always zero.

// File: rtl/sc_cpu_pkg.sv
package sc_cpu_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_is_rd;
    logic    use_imm;
    logic    mem_we;
    logic    mem_rd;
    logic    is_beq;
    logic    is_j;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_cpu_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (op)
      OP_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_we    = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_LW: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OP_SW: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ:  ctrl.is_beq = 1'b1;
      OP_J:    ctrl.is_j   = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  logic [W-1:0] diff;
  logic         less;

  assign diff = a - b;
  // signed compare: differing signs decide directly, else the difference sign
  assign less = (a[W-1] ^ b[W-1]) ? a[W-1] : diff[W-1];

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = diff;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, less};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd3
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];
endmodule

// File: rtl/sc_cpu.sv
module sc_cpu
  import sc_cpu_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_we,
  input  logic        ld_dmem,
  input  logic [31:0] ld_addr,
  input  logic [31:0] ld_data,
  output logic [31:0] pc_o,
  input  logic [4:0]  peek_reg,
  output logic [31:0] peek_reg_data,
  input  logic [31:0] peek_addr,
  output logic [31:0] peek_word
);
  localparam int IWORDS = 2 ** IMEM_AW;
  localparam int DWORDS = 2 ** DMEM_AW;

  logic [31:0] imem [IWORDS];
  logic [31:0] dmem [DWORDS];
  logic [31:0] pc_q, pc4, instr, imm_sx, br_target, j_target;
  logic [31:0] rs_val, rt_val, alu_b, alu_y, wb_data, dmem_rdata, peek_rf;
  logic [4:0]  wb_addr;
  ctrl_t       ctrl;
  logic        take_br;

  // fetch
  assign instr  = imem[pc_q[IMEM_AW+1:2]];
  assign pc4    = pc_q + 32'd4;
  assign imm_sx = {{16{instr[15]}}, instr[15:0]};

  sc_decoder u_dec (.op(instr[31:26]), .funct(instr[5:0]), .ctrl(ctrl));

  sc_regfile #(.W(32), .NREG(32)) u_rf (
    .clk(clk), .we(ctrl.reg_we && !rst), .waddr(wb_addr), .wdata(wb_data),
    .ra1(instr[25:21]), .rd1(rs_val),
    .ra2(instr[20:16]), .rd2(rt_val),
    .ra3(peek_reg),     .rd3(peek_rf)
  );

  assign alu_b = ctrl.use_imm ? imm_sx : rt_val;
  sc_alu #(.W(32)) u_alu (.a(rs_val), .b(alu_b), .op(ctrl.alu_op), .y(alu_y));

  // data memory: combinational read, write and preload on the edge
  assign dmem_rdata = dmem[alu_y[DMEM_AW+1:2]];
  always_ff @(posedge clk) begin
    if (ld_we && ld_dmem)         dmem[ld_addr[DMEM_AW+1:2]] <= ld_data;
    else if (!rst && ctrl.mem_we) dmem[alu_y[DMEM_AW+1:2]]   <= rt_val;
  end

  always_ff @(posedge clk) begin
    if (ld_we && !ld_dmem) imem[ld_addr[IMEM_AW+1:2]] <= ld_data;
  end

  assign wb_addr = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
  assign wb_data = ctrl.mem_rd ? dmem_rdata : alu_y;

  // next PC
  assign take_br   = ctrl.is_beq && (rs_val == rt_val);
  assign br_target = pc4 + {imm_sx[29:0], 2'b00};
  assign j_target  = {pc4[31:28], instr[25:0], 2'b00};

  always_ff @(posedge clk) begin
    if (rst)             pc_q <= '0;
    else if (ctrl.is_j)  pc_q <= j_target;
    else if (take_br)    pc_q <= br_target;
    else                 pc_q <= pc4;
  end
  assign pc_o = pc_q;

  // registered inspection ports
  always_ff @(posedge clk) begin
    peek_reg_data <= peek_rf;
    peek_word     <= dmem[peek_addr[DMEM_AW+1:2]];
  end

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], ld_addr, peek_addr, alu_y};

  // checks
  assert_pc_reset_R1: assert property (@(posedge clk) $past(rst) |-> pc_q == 32'd0);
  assert_pc_aligned_R9: assert property (@(posedge clk) disable iff (rst) pc_q[1:0] == 2'b00);
  assert_pc_step_R9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.is_j && !take_br) |=> pc_q == $past(pc_q) + 32'd4);
  assert_beq_target_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.is_beq && rs_val == rt_val) |=>
      pc_q == $past(pc_q) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});
  assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl.is_j |=> pc_q == {$past(pc_q[31:28]), $past(instr[25:0]), 2'b00});
  assert_slt_bool_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl.alu_op == ALU_SLT) |-> alu_y[31:1] == '0);
  assert_zero_reg_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(peek_reg) == 5'd0 && !$past(rst)) |-> peek_reg_data == 32'd0);
endmodule

// File: tb/sc_cpu_test.sv
module sc_cpu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0, ld_dmem = 1'b0;
  logic [31:0] ld_addr = '0, ld_data = '0, peek_addr = '0;
  logic [4:0]  peek_reg = '0;
  logic [31:0] pc_o, peek_reg_data, peek_word;

  int checks = 0, errors = 0;
  bit finished = 0, go = 0, mon_done = 0;

  typedef struct {int kind; logic [31:0] idx; logic [31:0] val; string tag;} item_t;
  item_t exp_q[$];

  always #2 clk = ~clk;

  sc_cpu uut (.clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
              .ld_data(ld_data), .pc_o(pc_o), .peek_reg(peek_reg),
              .peek_reg_data(peek_reg_data), .peek_addr(peek_addr), .peek_word(peek_word));

  function automatic logic [31:0] rop(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] iop(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic load(bit dm, int byte_addr, logic [31:0] w);
    @(negedge clk);
    ld_we = 1'b1; ld_dmem = dm; ld_addr = byte_addr; ld_data = w;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic push(int kind, logic [31:0] idx, logic [31:0] val, string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.val = val; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: kind 0 = PC at successive negedges, 1 = register peek, 2 = data peek
  initial begin
    wait (go);
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      if (it.kind == 0) begin
        check(it.tag, pc_o, it.val);
        @(negedge clk);
      end else if (it.kind == 1) begin
        peek_reg = it.idx[4:0];
        @(negedge clk);
        check(it.tag, peek_reg_data, it.val);
      end else begin
        peek_addr = it.idx;
        @(negedge clk);
        check(it.tag, peek_word, it.val);
      end
    end
    mon_done = 1;
  end

  initial begin
    // data preload (R10)
    load(1, 0, 32'd5);
    load(1, 4, 32'hFFFF_FFF9);
    load(1, 8, 32'h1234_5678);
    // program
    load(0,  0, iop(6'h23, 0, 1, 0));            // lw r1,0(r0)
    load(0,  4, iop(6'h23, 0, 2, 4));            // lw r2,4(r0)
    load(0,  8, iop(6'h23, 0, 3, 11));           // lw r3,11(r0) misaligned
    load(0, 12, rop(1, 2, 4, 6'h20));            // add r4
    load(0, 16, rop(1, 2, 5, 6'h22));            // sub r5
    load(0, 20, rop(3, 4, 6, 6'h24));            // and r6
    load(0, 24, rop(1, 2, 7, 6'h25));            // or r7
    load(0, 28, rop(2, 1, 8, 6'h2A));            // slt r8 = (-7<5)
    load(0, 32, rop(1, 2, 9, 6'h2A));            // slt r9 = (5<-7)
    load(0, 36, rop(1, 1, 0, 6'h20));            // add r0 (dropped)
    load(0, 40, iop(6'h2B, 5, 7, -1));           // sw r7,-1(r5) -> byte 11
    load(0, 44, iop(6'h2B, 1, 5, 7));            // sw r5,7(r1)  -> byte 12
    load(0, 48, iop(6'h04, 1, 2, 5));            // beq not taken
    load(0, 52, iop(6'h04, 0, 0, 2));            // beq taken -> 64
    load(0, 56, rop(1, 1, 9, 6'h20));            // skipped
    load(0, 60, rop(1, 1, 9, 6'h20));            // skipped
    load(0, 64, {6'h02, 26'd20});                // j 80
    load(0, 68, rop(1, 1, 8, 6'h20));            // skipped
    load(0, 72, 32'd0);
    load(0, 76, 32'd0);
    load(0, 80, rop(8, 8, 10, 6'h20));           // add r10 = 2
    load(0, 84, iop(6'h04, 0, 0, -1));           // beq self loop
    @(negedge clk);
    check("R1 pc under reset", pc_o, 32'd0);

    for (int a = 0; a <= 52; a += 4) push(0, 0, a, "R9 pc step");
    push(0, 0, 64, "R6 branch taken");
    push(0, 0, 80, "R7 jump");
    push(0, 0, 84, "R9 pc step");
    push(0, 0, 84, "R6 backward branch");
    push(0, 0, 84, "R6 backward branch");
    push(1, 1, 32'd5, "R4 lw");
    push(1, 2, 32'hFFFF_FFF9, "R4 lw");
    push(1, 3, 32'h1234_5678, "R4 lw low bits ignored");
    push(1, 4, 32'hFFFF_FFFE, "R2 add");
    push(1, 5, 32'd12, "R2 sub");
    push(1, 6, 32'h1234_5678, "R2 and");
    push(1, 7, 32'hFFFF_FFFD, "R2 or");
    push(1, 8, 32'd1, "R3 slt true / R7 skip");
    push(1, 9, 32'd0, "R3 slt false / R6 skip");
    push(1, 0, 32'd0, "R8 r0 zero");
    push(1, 10, 32'd2, "R7 jump landing");
    push(2, 8, 32'hFFFF_FFFD, "R5 sw negative offset");
    push(2, 12, 32'd12, "R5 sw");
    push(2, 4, 32'hFFFF_FFF9, "R10 preload kept");

    rst = 1'b0;
    go  = 1'b1;
    wait (mon_done);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule